// File: doc/BRIEF.md
# FIFO Status and Interrupt Register Bank

This block is the host-facing register bank that sits between a byte-wide register port and a pair of large data FIFOs: one for transmit and one for receive. It shows the live full, half-full and empty flags of both FIFOs. It keeps sticky interrupt source bits for receive pattern detection and for receive FIFO service. It holds the configuration for the pattern matcher and the receive timeout logic, and it issues one-cycle reset pulses to either FIFO. All enabled, pending sources are combined into a single interrupt request line.

The host reaches the bank through a 4-bit offset with a write strobe and write data. Read data is a combinational decode of the offset. Reads have no side effects. Offsets 0 through 7 belong to neighbouring logic, and this bank returns 0 there. The FIFO memories, the serial controller, the pattern matcher and the timeout counter lie outside the block. It only takes their flags and event pulses and drives their controls.

Top module: `fifo_irq_regbank`

## Requirements
- R1: After synchronous reset, every register this bank decodes reads 0, the interrupt request is low, and neither FIFO reset pulse is active.
- R2: Offset 9 reads the live FIFO flags with no register delay: bit 6 receive full, bit 5 receive half-full, bit 4 receive empty, bit 2 transmit full, bit 1 transmit half-full, bit 0 transmit empty; bits 7 and 3 read 0.
- R3: Interrupt status bit 3 (pattern) is set by a pattern-hit pulse only while control bit 6 (pattern enable) is 1. With the enable at 0, a hit leaves the bit unchanged.
- R4: Interrupt status bit 2 (receive FIFO) is set on the cycle the receive above-half input rises from 0 to 1, and not again while it stays high. It is also set by a timeout pulse while control bit 5 (timeout enable) is 1. With that enable at 0, a timeout pulse leaves the bit unchanged.
- R5: Writing offset 8 clears each status bit whose write-data bit is 1 and leaves the others. When a set event and a clear happen in the same cycle, the bit ends up set.
- R6: Offset A holds control bits 7 (receive FIFO interrupt enable), 6 and 5 as read/write bits. Writing 1 to bit 4 drives the receive FIFO reset output high for exactly the one cycle after the write. Writing 1 to bit 3 does the same for the transmit FIFO reset output. Bits 4 and 3 always read 0.
- R7: Offset B (pattern character, 8 bits) and offset C (pattern count, 8 bits) read back what was written. Offset D keeps bit 7 (divide-by-16 select) and bits 5..0 (timeout interval), and bit 6 reads 0.
- R8: The interrupt request equals (status bit 3 AND control bit 6) OR (status bit 2 AND control bit 7).
- R9: Offsets 0 to 7, E and F read 0, and writes to them change no register of this bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset from the base |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| rx_full | input | 1 | Receive FIFO full |
| rx_half | input | 1 | Receive FIFO at least half full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_above_half | input | 1 | Receive FIFO fill above the half mark |
| tx_full | input | 1 | Transmit FIFO full |
| tx_half | input | 1 | Transmit FIFO at least half full |
| tx_empty | input | 1 | Transmit FIFO empty |
| pat_hit | input | 1 | Pattern matcher event pulse |
| rx_timeout | input | 1 | Receive timeout event pulse |
| irq | output | 1 | Interrupt request |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset |
| pat_enable | output | 1 | Pattern detection enable |
| tmo_enable | output | 1 | Receive timeout enable |
| pat_char | output | 8 | Character to match |
| pat_count | output | 8 | Required consecutive match count |
| tmo_div16 | output | 1 | Prescale timeout clock by 16 |
| tmo_interval | output | 6 | Timeout interval in character times |

## Verification
A sticky bit stuck set or failing to clear shows up at once on irq and on the offset 8 read in the cycle after the write or event. Because of that, every event and clear is followed by an immediate read and an irq check. If the edge detector keeps a wrong previous value, the interrupt either retriggers while the level stays high or never fires. The bench therefore clears the bit with the level still high and reads it again. A reset pulse that lingers, or bits that leak into the control read-back, would show on the reset outputs within a cycle of the write. The bench samples the outputs in exactly that window.

// File: rtl/fifo_rb_pkg.sv
package fifo_rb_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int TMO_W  = 6;
    localparam int NSRC   = 2;

    localparam logic [ADDR_W-1:0] OFS_IST = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_FST = 4'h9;
    localparam logic [ADDR_W-1:0] OFS_CTL = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_PCH = 4'hB;
    localparam logic [ADDR_W-1:0] OFS_PCN = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_TMO = 4'hD;

    localparam int IST_RXF = 2;
    localparam int IST_PAT = 3;

    localparam int CTL_RXIE  = 7;
    localparam int CTL_PATEN = 6;
    localparam int CTL_TMOEN = 5;
    localparam int CTL_RXRST = 4;
    localparam int CTL_TXRST = 3;

    localparam int TMO_DIV_BIT = 7;

    typedef struct packed {
        logic full;
        logic half;
        logic empty;
    } fifo_flags_t;

    typedef struct packed {
        logic rx_ie;
        logic pat_en;
        logic tmo_en;
    } ctl_t;

    // index 0 = receive FIFO source, index 1 = pattern source
    typedef logic [NSRC-1:0] src_vec_t;

    function automatic logic [DATA_W-1:0] status_byte(fifo_flags_t rx, fifo_flags_t tx);
        return {1'b0, rx.full, rx.half, rx.empty, 1'b0, tx.full, tx.half, tx.empty};
    endfunction

    function automatic logic [DATA_W-1:0] ctl_byte(ctl_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[CTL_RXIE]  = c.rx_ie;
        b[CTL_PATEN] = c.pat_en;
        b[CTL_TMOEN] = c.tmo_en;
        return b;
    endfunction
endpackage

// File: rtl/rb_event_latch.sv
module rb_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) set_i |=> q); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !q); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst) (q && !clr_i) |=> q); // R3
endmodule

// File: rtl/rb_cfg_regs.sv
module rb_cfg_regs
    import fifo_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic              rx_rst,
    output logic              tx_rst,
    output logic [DATA_W-1:0] pat_char,
    output logic [DATA_W-1:0] pat_cnt,
    output logic              tmo_div,
    output logic [TMO_W-1:0]  tmo_ival
);
    logic wr_ctl, wr_pch, wr_pcn, wr_tmo;

    assign wr_ctl = wr_en && (addr == OFS_CTL);
    assign wr_pch = wr_en && (addr == OFS_PCH);
    assign wr_pcn = wr_en && (addr == OFS_PCN);
    assign wr_tmo = wr_en && (addr == OFS_TMO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            rx_rst   <= 1'b0;
            tx_rst   <= 1'b0;
            pat_char <= '0;
            pat_cnt  <= '0;
            tmo_div  <= 1'b0;
            tmo_ival <= '0;
        end else begin
            rx_rst <= wr_ctl && wdata[CTL_RXRST];
            tx_rst <= wr_ctl && wdata[CTL_TXRST];
            if (wr_ctl) begin
                ctl.rx_ie  <= wdata[CTL_RXIE];
                ctl.pat_en <= wdata[CTL_PATEN];
                ctl.tmo_en <= wdata[CTL_TMOEN];
            end
            if (wr_pch) pat_char <= wdata;
            if (wr_pcn) pat_cnt  <= wdata;
            if (wr_tmo) begin
                tmo_div  <= wdata[TMO_DIV_BIT];
                tmo_ival <= wdata[TMO_W-1:0];
            end
        end
    end

    AST_RXRST_PULSE: assert property (@(posedge clk) disable iff (rst) (wr_ctl && wdata[CTL_RXRST]) |=> rx_rst); // R6
    AST_RXRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) !(wr_ctl && wdata[CTL_RXRST]) |=> !rx_rst); // R6
    AST_TXRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) !(wr_ctl && wdata[CTL_TXRST]) |=> !tx_rst); // R6
    AST_PCH_STABLE: assert property (@(posedge clk) disable iff (rst) !wr_pch |=> $stable(pat_char)); // R9
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux
    import fifo_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          ist,
    input  fifo_flags_t       rx_flags,
    input  fifo_flags_t       tx_flags,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] pat_char,
    input  logic [DATA_W-1:0] pat_cnt,
    input  logic              tmo_div,
    input  logic [TMO_W-1:0]  tmo_ival,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_IST: begin
                rdata[IST_RXF] = ist[0];
                rdata[IST_PAT] = ist[1];
            end
            OFS_FST: rdata = status_byte(rx_flags, tx_flags);
            OFS_CTL: rdata = ctl_byte(ctl);
            OFS_PCH: rdata = pat_char;
            OFS_PCN: rdata = pat_cnt;
            OFS_TMO: begin
                rdata[TMO_DIV_BIT] = tmo_div;
                rdata[TMO_W-1:0]   = tmo_ival;
            end
            default: rdata = '0;
        endcase
    end

    AST_FST_RSV_BITS: assert property (@(posedge clk) disable iff (rst) (addr == OFS_FST) |-> (rdata[3] == 1'b0 && rdata[7] == 1'b0)); // R2
    AST_CTL_RST_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) (addr == OFS_CTL) |-> (rdata[CTL_RXRST] == 1'b0 && rdata[CTL_TXRST] == 1'b0)); // R6
    AST_TMO_BIT6_ZERO: assert property (@(posedge clk) disable iff (rst) (addr == OFS_TMO) |-> rdata[6] == 1'b0); // R7
endmodule

// File: rtl/fifo_irq_regbank.sv
module fifo_irq_regbank
    import fifo_rb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        rx_full,
    input  logic        rx_half,
    input  logic        rx_empty,
    input  logic        rx_above_half,
    input  logic        tx_full,
    input  logic        tx_half,
    input  logic        tx_empty,
    input  logic        pat_hit,
    input  logic        rx_timeout,
    output logic        irq,
    output logic        rx_fifo_rst,
    output logic        tx_fifo_rst,
    output logic        pat_enable,
    output logic        tmo_enable,
    output logic [7:0]  pat_char,
    output logic [7:0]  pat_count,
    output logic        tmo_div16,
    output logic [5:0]  tmo_interval
);
    ctl_t        ctl;
    fifo_flags_t rxf, txf;
    src_vec_t    ist, src_set, src_clr, src_en;
    logic        above_q;
    logic        wr_ist;

    assign rxf = '{full: rx_full, half: rx_half, empty: rx_empty};
    assign txf = '{full: tx_full, half: tx_half, empty: tx_empty};

    always_ff @(posedge clk) begin
        if (rst) above_q <= 1'b0;
        else     above_q <= rx_above_half;
    end

    assign wr_ist     = reg_wr && (reg_addr == OFS_IST);
    assign src_set[0] = (rx_above_half && !above_q) || (rx_timeout && ctl.tmo_en);
    assign src_set[1] = pat_hit && ctl.pat_en;
    assign src_clr[0] = wr_ist && reg_wdata[IST_RXF];
    assign src_clr[1] = wr_ist && reg_wdata[IST_PAT];
    assign src_en[0]  = ctl.rx_ie;
    assign src_en[1]  = ctl.pat_en;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        rb_event_latch u_latch (
            .clk   (clk),
            .rst   (rst),
            .set_i (src_set[i]),
            .clr_i (src_clr[i]),
            .q     (ist[i])
        );
    end

    assign irq = |(ist & src_en);

    rb_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ctl      (ctl),
        .rx_rst   (rx_fifo_rst),
        .tx_rst   (tx_fifo_rst),
        .pat_char (pat_char),
        .pat_cnt  (pat_count),
        .tmo_div  (tmo_div16),
        .tmo_ival (tmo_interval)
    );

    rb_read_mux u_rd (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .ist      (ist),
        .rx_flags (rxf),
        .tx_flags (txf),
        .ctl      (ctl),
        .pat_char (pat_char),
        .pat_cnt  (pat_count),
        .tmo_div  (tmo_div16),
        .tmo_ival (tmo_interval),
        .rdata    (reg_rdata)
    );

    assign pat_enable = ctl.pat_en;
    assign tmo_enable = ctl.tmo_en;

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst) irq |-> (ist != '0)); // R8
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst) (above_q && rx_above_half && !rx_timeout && src_clr[0]) |=> !ist[0]); // R4
    AST_PAT_MASKED: assert property (@(posedge clk) disable iff (rst) (!ist[1] && !ctl.pat_en) |=> !ist[1]); // R3
endmodule

// File: tb/tb_fifo_irq_regbank.sv
`timescale 1ns/1ps
module tb_fifo_irq_regbank;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic rx_full, rx_half, rx_empty, rx_above_half;
    logic tx_full, tx_half, tx_empty;
    logic pat_hit, rx_timeout;
    logic irq, rx_fifo_rst, tx_fifo_rst, pat_enable, tmo_enable, tmo_div16;
    logic [7:0] pat_char, pat_count;
    logic [5:0] tmo_interval;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fifo_irq_regbank dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_full(rx_full), .rx_half(rx_half), .rx_empty(rx_empty),
        .rx_above_half(rx_above_half), .tx_full(tx_full), .tx_half(tx_half),
        .tx_empty(tx_empty), .pat_hit(pat_hit), .rx_timeout(rx_timeout),
        .irq(irq), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
        .pat_enable(pat_enable), .tmo_enable(tmo_enable), .pat_char(pat_char),
        .pat_count(pat_count), .tmo_div16(tmo_div16), .tmo_interval(tmo_interval)
    );

    // {rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty, expected byte}
    localparam logic [13:0] FST_VEC [6] = '{
        {6'b000000, 8'h00},
        {6'b001001, 8'h11},
        {6'b010010, 8'h22},
        {6'b110100, 8'h64},
        {6'b100000, 8'h40},
        {6'b111111, 8'h77}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FIL%s %s got %h exp %h", "", req, got, exp);
        end
    endtask

    task automatic fail_line(input string req, input logic [7:0] got, input logic [7:0] exp);
        errors++;
        $display("FAIL %s got %h exp %h", req, got, exp);
    endtask

    task automatic ck(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) fail_line(req, got, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_pat();
        @(negedge clk); pat_hit = 1'b1;
        @(negedge clk); pat_hit = 1'b0;
    endtask

    task automatic pulse_tmo();
        @(negedge clk); rx_timeout = 1'b1;
        @(negedge clk); rx_timeout = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        {rx_full, rx_half, rx_empty, rx_above_half} = 4'b0010;
        {tx_full, tx_half, tx_empty} = 3'b001;
        pat_hit = 1'b0; rx_timeout = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 8; a < 16; a++) begin
            if (a == 9) continue;
            rd(a[3:0], v); ck("R1 reg after reset", v, 8'h00);
        end
        ck("R1 irq", {7'd0, irq}, 8'h00);
        ck("R1 reset pulses", {6'd0, rx_fifo_rst, tx_fifo_rst}, 8'h00);

        // R2 status table
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            {rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty} = FST_VEC[i][13:8];
            rd(4'h9, v); ck("R2 fifo status", v, FST_VEC[i][7:0]);
        end

        // R7 config registers
        wr(4'hB, 8'hA5); wr(4'hC, 8'h03); wr(4'hD, 8'hFF);
        rd(4'hB, v); ck("R7 pattern char", v, 8'hA5);
        rd(4'hC, v); ck("R7 pattern count", v, 8'h03);
        rd(4'hD, v); ck("R7 timeout reg bit6 zero", v, 8'hBF);
        ck("R7 timeout outputs", {tmo_div16, 1'b0, tmo_interval}, 8'hBF);

        // R9 reserved offsets
        wr(4'hE, 8'hFF); wr(4'hF, 8'hFF); wr(4'h3, 8'hFF);
        rd(4'hE, v); ck("R9 reserved E", v, 8'h00);
        rd(4'h3, v); ck("R9 reserved 3", v, 8'h00);
        rd(4'hB, v); ck("R9 pattern char untouched", v, 8'hA5);
        rd(4'hA, v); ck("R9 control untouched", v, 8'h00);

        // R3 pattern masked then enabled
        pulse_pat();
        rd(4'h8, v); ck("R3 masked pattern hit", v, 8'h00);
        wr(4'hA, 8'h40);
        pulse_pat();
        rd(4'h8, v); ck("R3 pattern sets bit3", v, 8'h08);
        ck("R8 irq from pattern", {7'd0, irq}, 8'h01);

        // R5 write-one-to-clear
        wr(4'h8, 8'h00);
        rd(4'h8, v); ck("R5 write zero keeps", v, 8'h08);
        wr(4'h8, 8'h08);
        rd(4'h8, v); ck("R5 write one clears", v, 8'h00);
        ck("R8 irq drops", {7'd0, irq}, 8'h00);

        // R4 rising edge of above-half
        @(negedge clk); rx_above_half = 1'b1;
        @(negedge clk);
        rd(4'h8, v); ck("R4 rx edge sets bit2", v, 8'h04);
        ck("R8 irq masked by rx enable", {7'd0, irq}, 8'h00);
        wr(4'hA, 8'hC0);
        ck("R8 irq with rx enable", {7'd0, irq}, 8'h01);
        wr(4'h8, 8'h04);
        @(negedge clk);
        rd(4'h8, v); ck("R4 no retrigger on level", v, 8'h00);
        @(negedge clk); rx_above_half = 1'b0;

        // R4 timeout masked then enabled
        pulse_tmo();
        rd(4'h8, v); ck("R4 masked timeout", v, 8'h00);
        wr(4'hA, 8'hE0);
        pulse_tmo();
        rd(4'h8, v); ck("R4 timeout sets bit2", v, 8'h04);
        wr(4'h8, 8'h04);

        // R5 set beats clear in same cycle
        @(negedge clk);
        reg_addr = 4'h8; reg_wdata = 8'h08; reg_wr = 1'b1; pat_hit = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; pat_hit = 1'b0;
        rd(4'h8, v); ck("R5 set wins over clear", v, 8'h08);
        wr(4'h8, 8'h0C);

        // R6 reset pulses
        @(negedge clk);
        reg_addr = 4'hA; reg_wdata = 8'hF8; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        ck("R6 both reset pulses high", {6'd0, rx_fifo_rst, tx_fifo_rst}, 8'h03);
        rd(4'hA, v); ck("R6 control readback", v, 8'hE0);
        @(negedge clk);
        ck("R6 reset pulses self clear", {6'd0, rx_fifo_rst, tx_fifo_rst}, 8'h00);
        ck("R6 enables out", {6'd0, pat_enable, tmo_enable}, 8'h03);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule